// File: doc/BRIEF.md
# I2C Slave Controller with General Call Handling

This block is a 7-bit-address I2C bus slave that runs from a fast system clock. SCL and SDA pass through two-flop synchronisers. The block pulls either line low through an output-enable, so the pads act as open-drain outputs. Software reaches a small register interface to enable the slave, program its address and load the byte to send. It reads received bytes and status there, and clears interrupt flags by writing ones.

The block also handles general calls. Address 0x00 in the write direction is acknowledged when general calls are enabled. The data byte that follows is decoded as follows:

- 0x06 reloads the slave address from a preset value and resets the interface.
- 0x04 reloads only the address.
- A byte equal to the alternate-ID register is a hardware general call.

Software can force clock stretching, and it can tell the slave to refuse the next received byte. A transmit-request flag is raised for read transfers. It comes either just after the rising edge of SCL during the read/write bit, or just after that bit's falling edge.

Top module: `i2c_gc_slave`

## Requirements
- R1: While the enable bit (ctrl[0]) is clear, the slave ignores the bus and releases both lines. It acknowledges no address, and scl_oe and sda_oe are 0 one cycle after the bit is clear.
- R2: With the slave enabled, an address byte whose upper seven bits equal the address register (reg 3, reset value DFLT_ADDR) is acknowledged; any other address is refused. A written data byte is acknowledged, stored in the receive register (reg 5 read), and sets the receive flag (status[0] is transmit, status[1] receive, status[2] stop; status is reg 2).
- R3: Address byte 0x00 is acknowledged only when the general call enable (ctrl[1]) is set. The data byte after it is acknowledged too.
- R4: A general call data byte of 0x06 sets the ID field (status[5:4]) to 1. It reloads the address register with DFLT_ADDR and clears the receive and transmit data registers.
- R5: A general call data byte of 0x04 sets the ID field to 2 and reloads the address register. The receive register is left unchanged.
- R6: With the hardware general call enable (ctrl[2]) and ctrl[1] set, a general call data byte equal to the alternate-ID register (reg 4) sets the ID field to 3. Bit 0 of the alternate-ID register always reads and compares as 1. Any other data byte that is not a command leaves the ID field at 0.
- R7: Every general call data byte sets the general call flag (status[3]). Writing 1 to status bit 3 clears both that flag and the ID field, and the ID field is never nonzero while the flag is clear.
- R8: When the refuse-next bit (ctrl[5]) is set, the next received data byte is answered with NACK and the bit clears itself. Later bytes are acknowledged again.
- R9: Setting the stretch bit (ctrl[4]) while SCL is low holds SCL low until software clears the bit. Setting it while SCL is high starts the hold at the next falling edge of SCL. The slave never pulls SCL low unless the bit was set.
- R10: For a matched read address, the transmit flag sets just after the rising SCL edge of the read/write bit when early mode (ctrl[3]) is set. When early mode is clear, it sets just after that bit's falling edge.
- R11: In a read, the transmit register is shifted out MSB first. A master ACK reloads it for the next byte and sets the transmit flag again. A master NACK releases SDA until the next start or stop.
- R12: A stop condition sets the stop flag. irq is high while any of the transmit, receive or stop flags is set together with its enable bit (reg 1 bits 0, 1, 2), and writing 1 to a flag's status bit clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| irq | output | 1 | Interrupt request |

## Verification
Software can turn on stretching at the moment the slave is driving the address acknowledge. In that case one SCL-low phase carries both the SCL hold and the SDA acknowledge. The bench provokes this by setting the stretch bit right after the eighth falling edge of a matching address. It then checks that both output-enables are high together, and that SCL stays low after the master releases it. Once the bit is cleared, the master must still sample the acknowledge, and the following data byte must land in the receive register.

// File: rtl/i2c_gc_slave.sv
module i2c_gc_slave #(
  parameter logic [6:0] DFLT_ADDR = 7'h2A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       reg_we,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq
);
  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_RX, S_RACK, S_TX, S_TACK, S_WAIT} st_t;

  logic [1:0] scl_q, sda_q;
  logic       scl_p, sda_p;
  logic       en, gc_en, hwgc_en, early_tx, stretch, nack_next;
  logic       tx_ie, rx_ie, stop_ie;
  logic       f_tx, f_rx, f_stop, f_gc;
  logic [1:0] gc_id;
  logic [6:0] my_addr;
  logic [7:1] alt_id;
  logic [7:0] txd, rxd, sh;
  logic [3:0] cnt;
  logic       rw, is_gc, done, m_ack, hold, sda_drv;
  st_t        st;

  wire scl_s   = scl_q[1];
  wire sda_s   = sda_q[1];
  wire rise    = scl_s & ~scl_p;
  wire fall    = ~scl_s & scl_p;
  wire start_c = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_c  = scl_s & scl_p & ~sda_p & sda_s;

  wire [7:0] byte_now = {sh[6:0], sda_s};
  wire now_hit = (byte_now[7:1] == my_addr) | (gc_en & (byte_now == 8'h00));
  wire sh_hit  = (sh[7:1] == my_addr) | (gc_en & (sh == 8'h00));

  assign scl_oe = hold;
  assign sda_oe = sda_drv;
  assign irq    = (f_tx & tx_ie) | (f_rx & rx_ie) | (f_stop & stop_ie);

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {2'b00, nack_next, stretch, early_tx, hwgc_en, gc_en, en};
      3'd1:    reg_rdata = {5'b0, stop_ie, rx_ie, tx_ie};
      3'd2:    reg_rdata = {2'b00, gc_id, f_gc, f_stop, f_rx, f_tx};
      3'd3:    reg_rdata = {1'b0, my_addr};
      3'd4:    reg_rdata = {alt_id, 1'b1};
      3'd5:    reg_rdata = rxd;
      default: reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 2'b11; sda_q <= 2'b11; scl_p <= 1'b1; sda_p <= 1'b1;
      {en, gc_en, hwgc_en, early_tx, stretch, nack_next} <= '0;
      {tx_ie, rx_ie, stop_ie} <= '0;
      {f_tx, f_rx, f_stop, f_gc} <= '0;
      gc_id <= '0; my_addr <= DFLT_ADDR; alt_id <= '0;
      txd <= '0; rxd <= '0; sh <= '0; cnt <= '0;
      {rw, is_gc, done, m_ack, hold, sda_drv} <= '0;
      st <= S_IDLE;
    end else begin
      scl_q <= {scl_q[0], scl_i}; sda_q <= {sda_q[0], sda_i};
      scl_p <= scl_s; sda_p <= sda_s;
      hold  <= en & stretch & (hold | ~scl_s);

      if (reg_we) begin
        case (reg_addr)
          3'd0: {nack_next, stretch, early_tx, hwgc_en, gc_en, en} <= reg_wdata[5:0];
          3'd1: {stop_ie, rx_ie, tx_ie} <= reg_wdata[2:0];
          3'd2: begin
            if (reg_wdata[0]) f_tx <= 1'b0;
            if (reg_wdata[1]) f_rx <= 1'b0;
            if (reg_wdata[2]) f_stop <= 1'b0;
            if (reg_wdata[3]) begin f_gc <= 1'b0; gc_id <= 2'd0; end
          end
          3'd3: my_addr <= reg_wdata[6:0];
          3'd4: alt_id <= reg_wdata[7:1];
          3'd5: txd <= reg_wdata;
          default: ;
        endcase
      end

      if (!en) begin
        st <= S_IDLE; sda_drv <= 1'b0;
      end else if (stop_c) begin
        st <= S_IDLE; sda_drv <= 1'b0; f_stop <= 1'b1;
      end else if (start_c) begin
        st <= S_ADDR; cnt <= '0; sda_drv <= 1'b0;
      end else begin
        case (st)
          S_ADDR: begin
            if (rise) begin
              sh <= byte_now; cnt <= cnt + 4'd1;
              if (cnt == 4'd7 && now_hit && byte_now[0] && early_tx) f_tx <= 1'b1;
            end
            if (fall && cnt == 4'd8) begin
              if (sh_hit) begin
                st <= S_AACK; sda_drv <= 1'b1; rw <= sh[0]; is_gc <= (sh == 8'h00);
                if (sh[0] && !early_tx) f_tx <= 1'b1;
              end else st <= S_WAIT;
            end
          end
          S_AACK: if (fall) begin
            cnt <= '0;
            if (rw) begin sh <= txd; sda_drv <= ~txd[7]; st <= S_TX; end
            else begin sda_drv <= 1'b0; st <= S_RX; end
          end
          S_RX: begin
            if (rise) begin sh <= byte_now; cnt <= cnt + 4'd1; end
            if (fall && cnt == 4'd8) begin
              sda_drv <= ~nack_next; nack_next <= 1'b0;
              done <= is_gc | nack_next; st <= S_RACK;
              if (is_gc) begin
                f_gc <= 1'b1;
                if (hwgc_en && gc_en && sh == {alt_id, 1'b1}) gc_id <= 2'd3;
                else if (sh == 8'h06) begin
                  gc_id <= 2'd1; my_addr <= DFLT_ADDR; rxd <= '0; txd <= '0;
                end else if (sh == 8'h04) begin
                  gc_id <= 2'd2; my_addr <= DFLT_ADDR;
                end else gc_id <= 2'd0;
              end else begin
                rxd <= sh; f_rx <= 1'b1;
              end
            end
          end
          S_RACK: if (fall) begin
            sda_drv <= 1'b0; cnt <= '0;
            st <= done ? S_WAIT : S_RX;
          end
          S_TX: begin
            if (rise) cnt <= cnt + 4'd1;
            if (fall) begin
              if (cnt == 4'd8) begin sda_drv <= 1'b0; st <= S_TACK; end
              else begin sda_drv <= ~sh[6]; sh <= {sh[6:0], 1'b0}; end
            end
          end
          S_TACK: begin
            if (rise) m_ack <= ~sda_s;
            if (fall) begin
              if (m_ack) begin
                sh <= txd; sda_drv <= ~txd[7]; cnt <= '0; f_tx <= 1'b1; st <= S_TX;
              end else st <= S_WAIT;
            end
          end
          S_IDLE, S_WAIT: ;
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

module i2c_gc_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       stretch,
  input logic       scl_s,
  input logic       scl_p,
  input logic       sda_s,
  input logic       sda_p,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       f_gc,
  input logic [1:0] gc_id,
  input logic       f_stop
);
  assert_release_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!sda_oe && !scl_oe));
  assert_hold_needs_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
    scl_oe |-> $past(stretch));
  assert_hold_from_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && stretch && !scl_s) |=> scl_oe);
  assert_id_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (gc_id != 2'd0) |-> f_gc);
  assert_stop_sets_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (en && scl_s && scl_p && !sda_p && sda_s) |=> f_stop);
endmodule

bind i2c_gc_slave i2c_gc_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .stretch(stretch),
  .scl_s(scl_s), .scl_p(scl_p), .sda_s(sda_s), .sda_p(sda_p),
  .scl_oe(scl_oe), .sda_oe(sda_oe), .f_gc(f_gc), .gc_id(gc_id), .f_stop(f_stop)
);

// File: tb/i2c_gc_slave_bench.sv
module i2c_gc_slave_bench;
  localparam int H = 20;
  logic clk = 0, rst_n = 0;
  logic m_scl_low = 0, m_sda_low = 0;
  logic reg_we = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic scl_oe, sda_oe, irq, scl_bus, sda_bus;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;
  assign scl_bus = ~(m_scl_low | scl_oe);
  assign sda_bus = ~(m_sda_low | sda_oe);

  i2c_gc_slave u_i2c_gc_slave (.clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  // {address byte, data byte, expected acknowledge}
  localparam logic [16:0] VEC [0:3] = '{
    {8'h54, 8'h5A, 1'b1}, {8'h56, 8'h11, 1'b0}, {8'h00, 8'h77, 1'b0}, {8'h54, 8'hC3, 1'b1}};

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wt(input int n); repeat (n) @(posedge clk); endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic pulse(output logic smp);
    m_scl_low = 0; wait (scl_bus); wt(H/2); smp = sda_bus; wt(H/2);
    m_scl_low = 1; wt(H);
  endtask

  task automatic start_c;
    m_sda_low = 0; m_scl_low = 0; wait (scl_bus); wt(H);
    m_sda_low = 1; wt(H); m_scl_low = 1; wt(H);
  endtask

  task automatic stop_c;
    m_sda_low = 1; wt(H/2); m_scl_low = 0; wait (scl_bus); wt(H);
    m_sda_low = 0; wt(H);
  endtask

  task automatic put_bit(input logic b);
    logic x;
    m_sda_low = ~b; wt(H/2); pulse(x);
  endtask

  task automatic get_ack(output logic ack);
    logic x;
    m_sda_low = 0; wt(H/2); pulse(x); ack = ~x;
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_ack(ack);
  endtask

  task automatic get_byte(output logic [7:0] d, input logic ack_it);
    logic x;
    m_sda_low = 0;
    for (int i = 0; i < 8; i++) begin pulse(x); d = {d[6:0], x}; end
    m_sda_low = ack_it; pulse(x); m_sda_low = 0;
  endtask

  task automatic gc_xfer(input logic [7:0] cmd);
    logic a;
    start_c; put_byte(8'h00, a); chk("R3 gc address ack", {7'b0, a}, 8'h01);
    put_byte(cmd, a); chk("R3 gc data ack", {7'b0, a}, 8'h01); stop_c;
  endtask

  initial begin
    wt(150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic a;
    wt(3); rst_n = 1; wt(3);
    // reset state
    rd(3'd3, d); chk("R2 reset address", d, 8'h2A);
    rd(3'd2, d); chk("R12 reset status", d, 8'h00);
    rd(3'd0, d); chk("R1 reset ctrl", d, 8'h00);
    chk("R1 reset outputs", {5'b0, irq, scl_oe, sda_oe}, 8'h00);
    // disabled slave ignores its own address
    start_c; put_byte(8'h54, a); chk("R1 disabled no ack", {7'b0, a}, 8'h00);
    chk("R1 lines released", {6'b0, scl_oe, sda_oe}, 8'h00); stop_c;
    rd(3'd2, d); chk("R1 disabled no stop flag", d, 8'h00);

    wr(3'd0, 8'h01);
    for (int i = 0; i < 4; i++) begin
      start_c; put_byte(VEC[i][16:9], a);
      chk("R2 vector address ack", {7'b0, a}, {7'b0, VEC[i][0]});
      if (a) begin
        put_byte(VEC[i][8:1], a); chk("R2 vector data ack", {7'b0, a}, 8'h01);
      end
      stop_c;
      if (VEC[i][0]) begin
        rd(3'd5, d); chk("R2 vector rx data", d, VEC[i][8:1]);
        rd(3'd2, d); chk("R2 rx flag", {7'b0, d[1]}, 8'h01);
      end
      wr(3'd2, 8'h0F);
    end

    // irq gating and W1C (R12)
    wr(3'd1, 8'h02);
    start_c; put_byte(8'h54, a); put_byte(8'h66, a); stop_c;
    wt(2); chk("R12 irq from rx", {7'b0, irq}, 8'h01);
    wr(3'd2, 8'h02); wt(1); chk("R12 irq after clear", {7'b0, irq}, 8'h00);
    wr(3'd1, 8'h00); wr(3'd2, 8'h0F);

    // general call 0x06 (R4)
    wr(3'd0, 8'h03); wr(3'd3, 8'h11);
    gc_xfer(8'h06);
    rd(3'd3, d); chk("R4 address reloaded", d, 8'h2A);
    rd(3'd5, d); chk("R4 rx cleared", d, 8'h00);
    rd(3'd2, d); chk("R4 id and flag", d[5:3], 3'b011);
    wr(3'd2, 8'h08); rd(3'd2, d); chk("R7 clear flag and id", d[5:3], 3'b000);

    // general call 0x04 (R5)
    start_c; put_byte(8'h54, a); put_byte(8'h4D, a); stop_c;
    wr(3'd3, 8'h13);
    gc_xfer(8'h04);
    rd(3'd3, d); chk("R5 address reloaded", d, 8'h2A);
    rd(3'd5, d); chk("R5 rx unchanged", d, 8'h4D);
    rd(3'd2, d); chk("R5 id and flag", d[5:3], 3'b101);
    wr(3'd2, 8'h0F);

    // hardware general call (R6)
    wr(3'd4, 8'h5A); rd(3'd4, d); chk("R6 alt id lsb forced", d, 8'h5B);
    wr(3'd0, 8'h07);
    gc_xfer(8'h5B);
    rd(3'd2, d); chk("R6 hardware id", d[5:3], 3'b111);
    wr(3'd2, 8'h08);
    gc_xfer(8'h33);
    rd(3'd2, d); chk("R6 no match id zero R7 flag", d[5:3], 3'b001);
    wr(3'd2, 8'h08); wr(3'd0, 8'h03);
    gc_xfer(8'h5B);
    rd(3'd2, d); chk("R6 hw disabled id zero", d[5:3], 3'b001);
    wr(3'd2, 8'h0F);
    wr(3'd0, 8'h01);
    start_c; put_byte(8'h00, a); chk("R3 gc disabled nack", {7'b0, a}, 8'h00); stop_c;

    // refuse next byte (R8)
    wr(3'd0, 8'h21);
    start_c; put_byte(8'h54, a); chk("R8 address still acked", {7'b0, a}, 8'h01);
    put_byte(8'h10, a); chk("R8 forced nack", {7'b0, a}, 8'h00); stop_c;
    rd(3'd0, d); chk("R8 bit self clears", {7'b0, d[5]}, 8'h00);
    start_c; put_byte(8'h54, a); put_byte(8'h20, a); stop_c;
    chk("R8 later byte acked", {7'b0, a}, 8'h01);
    wr(3'd2, 8'h0F);

    // stretch requested while SCL high (R9)
    wr(3'd1, 8'h04);
    wr(3'd0, 8'h11); wt(10); chk("R9 no hold while high", {7'b0, scl_oe}, 8'h00);
    start_c; wt(5); chk("R9 hold after falling edge", {7'b0, scl_oe}, 8'h01);
    m_scl_low = 0; wt(2*H); chk("R9 scl kept low", {7'b0, scl_bus}, 8'h00);
    wr(3'd0, 8'h01); wt(H); chk("R9 scl freed", {7'b0, scl_bus}, 8'h01);
    m_sda_low = 0; wt(H);
    wt(2); chk("R12 stop irq", {7'b0, irq}, 8'h01);
    wr(3'd2, 8'h04); wt(1); chk("R12 stop cleared", {7'b0, irq}, 8'h00);
    wr(3'd1, 8'h00);

    // stretch set during the address acknowledge (R9 with R2)
    start_c;
    for (int i = 7; i >= 0; i--) put_bit(8'h54 >> i);
    m_sda_low = 0; wt(5); wr(3'd0, 8'h11); wt(5);
    chk("R9 hold with ack drive", {6'b0, scl_oe, sda_oe}, 8'h03);
    m_scl_low = 0; wt(2*H); chk("R9 scl low during ack", {7'b0, scl_bus}, 8'h00);
    wr(3'd0, 8'h01);
    begin logic x; wait (scl_bus); wt(H/2); x = sda_bus; wt(H/2); m_scl_low = 1; wt(H);
      chk("R2 ack after stretch", {7'b0, x}, 8'h00); end
    put_byte(8'h3C, a); stop_c;
    rd(3'd5, d); chk("R2 data after stretch", d, 8'h3C);
    wr(3'd2, 8'h0F);

    // read with early transmit request (R10, R11)
    wr(3'd5, 8'hA5); wr(3'd0, 8'h09); wr(3'd2, 8'h01);
    start_c;
    for (int i = 6; i >= 0; i--) put_bit(7'h2A >> i);
    m_sda_low = 0; wt(H/2); m_scl_low = 0; wait (scl_bus); wt(8);
    rd(3'd2, d); chk("R10 early flag after rise", {7'b0, d[0]}, 8'h01);
    wt(H/2); m_scl_low = 1; wt(H);
    get_ack(a); chk("R11 read address ack", {7'b0, a}, 8'h01);
    get_byte(d, 1'b0); chk("R11 read byte", d, 8'hA5);
    stop_c; wr(3'd2, 8'h0F);

    // read with late transmit request (R10, R11)
    wr(3'd0, 8'h01);
    start_c;
    for (int i = 6; i >= 0; i--) put_bit(7'h2A >> i);
    m_sda_low = 0; wt(H/2); m_scl_low = 0; wait (scl_bus); wt(8);
    rd(3'd2, d); chk("R10 late flag not yet", {7'b0, d[0]}, 8'h00);
    wt(H/2); m_scl_low = 1; wt(10);
    rd(3'd2, d); chk("R10 late flag after fall", {7'b0, d[0]}, 8'h01);
    wt(H); get_ack(a);
    wr(3'd2, 8'h01);
    get_byte(d, 1'b1); chk("R11 first byte", d, 8'hA5);
    rd(3'd2, d); chk("R11 reload sets flag", {7'b0, d[0]}, 8'h01);
    get_byte(d, 1'b0); chk("R11 second byte", d, 8'hA5);
    chk("R11 sda released after nack", {7'b0, sda_oe}, 8'h00);
    stop_c;

    // disable clears drive (R1)
    wr(3'd0, 8'h11); start_c; wt(5); wr(3'd0, 8'h00); wt(2);
    chk("R1 disable releases", {6'b0, scl_oe, sda_oe}, 8'h00);
    stop_c;

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule